// File: doc/BRIEF.md
# Digital Potentiometer Wiper and Data Register Bank

This block is the register core of a four-channel digital potentiometer. Each channel owns one volatile wiper register, which sets the active tap of its resistor ladder, and four data registers that stand in for nonvolatile storage. The block receives already decoded commands from a serial front end, one per cycle. It carries out reads, direct writes, single-channel and all-channel transfers between wiper and data registers, and saturating one-step moves of a wiper. For each channel it drives a one-hot tap select vector.

Every command that changes a data register counts as a nonvolatile store. A store raises a busy flag for a parameterised number of cycles, which models the programming time. While the flag is high, further stores are dropped. A write-protect input that is low blocks all stores. Two resets are kept apart: a power-on reset that sets the data registers to a parameter value, and a soft reset that clears only volatile state. During either reset, each wiper is recalled from data register 0 of its own channel.

Top module: `potbank_top`

## Requirements
- R1: While `rst_n` or `por_n` is low, each wiper register loads data register 0 of its own channel. `por_n` low sets every data register to `INIT_VALUE`. A pulse on `rst_n` alone leaves the data registers unchanged.
- R2: Opcode 2 loads `cmd_wdata` into the wiper of channel `cmd_pot`.
- R3: Opcode 9 moves the wiper of channel `cmd_pot` by one step: up when `cmd_wdata[0]` is 1, down when it is 0. The value saturates at all-ones and at zero and never wraps.
- R4: Opcode 5 copies data register `cmd_reg` of channel `cmd_pot` into that channel's wiper. Opcode 7 does the same for every channel in one cycle, using each channel's own register `cmd_reg`.
- R5: Three opcodes are stores. Opcode 4 writes `cmd_wdata` into data register `cmd_reg` of channel `cmd_pot`. Opcode 6 copies that channel's wiper into its data register `cmd_reg`. Opcode 8 copies every channel's wiper into its own data register `cmd_reg`.
- R6: An accepted store sets `store_busy` high for exactly `STORE_CYCLES` cycles, starting in the cycle after the command. A store issued while `store_busy` is high is ignored. Wiper commands still execute during that time.
- R7: While `wp_n` is low, stores change no data register and do not raise `store_busy`. Wiper commands still execute.
- R8: Opcode 1 reads the wiper, opcode 3 reads a data register and opcode 10 reads the status byte `{0000000, store_busy}`. In each case `rd_valid` is high with `rd_data` in the cycle after the command, and the value returned is the one held before the command's clock edge.
- R9: `tap_sel[p*2**DATA_W +: 2**DATA_W]` has exactly one bit set, at the bit index equal to channel p's wiper value. Index 0 is the low terminal and index all-ones is the high terminal.
- R10: A command that is not global changes only the channel chosen by `cmd_pot`, and only the register chosen by `cmd_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; also initialises the data registers |
| rst_n | input | 1 | Soft reset, active low, synchronous; clears volatile state only |
| wp_n | input | 1 | Write protect, active low; blocks stores |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_pot | input | $clog2(NUM_POTS) | Channel select |
| cmd_reg | input | $clog2(NUM_REGS) | Data register select |
| cmd_wdata | input | DATA_W | Write data; bit 0 gives the step direction |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| store_busy | output | 1 | Store cycle in progress |
| tap_sel | output | NUM_POTS*2**DATA_W | One-hot tap select for each channel |

## Verification
The busy window of a store and the wiper path are independent, so a wiper write, a status read and a dropped second store can all land while the timer is running. The bench issues them back to back inside that window. It then judges the outcome at the ports: the wiper has moved, the status read returns 1, and the data register reads back its first stored value. The same approach covers write protect and a global store in the same test. A global store with `wp_n` low must leave every data register as it was, while a wiper write in that same stretch takes effect.

// File: rtl/potbank_pkg.sv
package potbank_pkg;

   typedef enum logic [3:0] {
      OP_NOP      = 4'd0,
      OP_RD_WIPER = 4'd1,
      OP_WR_WIPER = 4'd2,
      OP_RD_SLOT  = 4'd3,
      OP_WR_SLOT  = 4'd4,
      OP_LOAD_ONE = 4'd5,
      OP_SAVE_ONE = 4'd6,
      OP_LOAD_ALL = 4'd7,
      OP_SAVE_ALL = 4'd8,
      OP_STEP     = 4'd9,
      OP_RD_BUSY  = 4'd10
   } op_e;

   function automatic logic is_store(op_e op);
      return (op == OP_WR_SLOT) || (op == OP_SAVE_ONE) || (op == OP_SAVE_ALL);
   endfunction

   function automatic logic is_read(op_e op);
      return (op == OP_RD_WIPER) || (op == OP_RD_SLOT) || (op == OP_RD_BUSY);
   endfunction

endpackage

// File: rtl/potbank_timer.sv
module potbank_timer #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CNT_W = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("potbank_timer: CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (start)        cnt <= CNT_W'(CYCLES);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   // R6: a started store is visible as busy in the next cycle
   p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   // R6: the owner must never restart a running store
   p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   // R6: busy holds until the last counted cycle
   p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt > 1) |=> busy);
endmodule

// File: rtl/potbank_decoder.sv
module potbank_decoder #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0]      value,
   output logic [(1<<WIDTH)-1:0] onehot
);
   localparam int TAPS = 1 << WIDTH;

   generate
      for (genvar i = 0; i < TAPS; i++) begin : g_tap
         assign onehot[i] = (value == WIDTH'(i));
      end
   endgenerate
endmodule

// File: rtl/potbank_channel.sv
module potbank_channel #(
   parameter int               WIDTH = 8,
   parameter int               NREGS = 4,
   parameter logic [WIDTH-1:0] INIT  = '0
) (
   input  logic                     clk,
   input  logic                     por_n,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [WIDTH-1:0]         wr_val,
   input  logic                     step_en,
   input  logic                     step_up,
   input  logic                     load_en,
   input  logic [$clog2(NREGS)-1:0] load_idx,
   input  logic                     save_en,
   input  logic [$clog2(NREGS)-1:0] save_idx,
   input  logic [WIDTH-1:0]         save_val,
   output logic [WIDTH-1:0]         wiper,
   output logic [NREGS*WIDTH-1:0]   slots
);
   localparam int               IDX_W = $clog2(NREGS);
   localparam logic [WIDTH-1:0] TOP   = '1;

   logic [WIDTH-1:0] slot [NREGS];

   generate
      for (genvar r = 0; r < NREGS; r++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!por_n)                                  slot[r] <= INIT;
            else if (save_en && save_idx == IDX_W'(r))   slot[r] <= save_val;
         end
         assign slots[r*WIDTH +: WIDTH] = slot[r];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        wiper <= slot[0];
      else if (wr_en)    wiper <= wr_val;
      else if (load_en)  wiper <= slot[load_idx];
      else if (step_en) begin
         if (step_up) wiper <= (wiper == TOP) ? wiper : wiper + 1'b1;
         else         wiper <= (wiper == '0)  ? wiper : wiper - 1'b1;
      end
   end

   // R1: soft reset recalls register 0 into the wiper
   p_recall_r1: assert property (@(posedge clk) disable iff (!por_n)
      !rst_n |=> wiper == $past(slot[0]));
   // R3: upward step holds at the top
   p_sat_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && step_up && !wr_en && !load_en && wiper == TOP) |=> wiper == TOP);
   // R3: downward step holds at zero
   p_sat_bot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !step_up && !wr_en && !load_en && wiper == '0) |=> wiper == '0);
endmodule

// File: rtl/potbank_top.sv
module potbank_top
   import potbank_pkg::*;
#(
   parameter int                DATA_W       = 8,
   parameter int                NUM_POTS     = 4,
   parameter int                NUM_REGS     = 4,
   parameter int                STORE_CYCLES = 1000,
   parameter logic [DATA_W-1:0] INIT_VALUE   = 8'h80
) (
   input  logic                              clk,
   input  logic                              por_n,
   input  logic                              rst_n,
   input  logic                              wp_n,
   input  logic                              cmd_valid,
   input  logic [3:0]                        cmd_op,
   input  logic [$clog2(NUM_POTS)-1:0]       cmd_pot,
   input  logic [$clog2(NUM_REGS)-1:0]       cmd_reg,
   input  logic [DATA_W-1:0]                 cmd_wdata,
   output logic                              rd_valid,
   output logic [DATA_W-1:0]                 rd_data,
   output logic                              store_busy,
   output logic [NUM_POTS*(1<<DATA_W)-1:0]   tap_sel
);
   localparam int TAPS  = 1 << DATA_W;
   localparam int POT_W = $clog2(NUM_POTS);
   localparam int REG_W = $clog2(NUM_REGS);

   generate
      if (DATA_W < 2 || DATA_W > 10) begin : g_bad_width
         $error("potbank_top: DATA_W out of range");
      end
      if (NUM_POTS < 2 || (1 << POT_W) != NUM_POTS) begin : g_bad_pots
         $error("potbank_top: NUM_POTS must be a power of two >= 2");
      end
      if (NUM_REGS < 2 || (1 << REG_W) != NUM_REGS) begin : g_bad_regs
         $error("potbank_top: NUM_REGS must be a power of two >= 2");
      end
   endgenerate

   op_e  op;
   logic sys_rst_n;
   logic store_ok;

   assign op        = op_e'(cmd_op);
   assign sys_rst_n = rst_n & por_n;
   assign store_ok  = cmd_valid && is_store(op) && wp_n && !store_busy;

   logic [DATA_W-1:0]                         wiper [NUM_POTS];
   logic [NUM_POTS-1:0][NUM_REGS*DATA_W-1:0]  slots_all;

   generate
      for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
         logic              hit, wr_en, step_en, load_en, save_en;
         logic [DATA_W-1:0] save_val;

         assign hit      = (cmd_pot == POT_W'(p));
         assign wr_en    = cmd_valid && op == OP_WR_WIPER && hit;
         assign step_en  = cmd_valid && op == OP_STEP && hit;
         assign load_en  = cmd_valid && ((op == OP_LOAD_ONE && hit) || op == OP_LOAD_ALL);
         assign save_en  = store_ok &&
                           (((op == OP_WR_SLOT || op == OP_SAVE_ONE) && hit) || op == OP_SAVE_ALL);
         assign save_val = (op == OP_WR_SLOT) ? cmd_wdata : wiper[p];

         potbank_channel #(
            .WIDTH (DATA_W),
            .NREGS (NUM_REGS),
            .INIT  (INIT_VALUE)
         ) chan_i (
            .clk      (clk),
            .por_n    (por_n),
            .rst_n    (sys_rst_n),
            .wr_en    (wr_en),
            .wr_val   (cmd_wdata),
            .step_en  (step_en),
            .step_up  (cmd_wdata[0]),
            .load_en  (load_en),
            .load_idx (cmd_reg),
            .save_en  (save_en),
            .save_idx (cmd_reg),
            .save_val (save_val),
            .wiper    (wiper[p]),
            .slots    (slots_all[p])
         );

         potbank_decoder #(.WIDTH(DATA_W)) dec_i (
            .value  (wiper[p]),
            .onehot (tap_sel[p*TAPS +: TAPS])
         );

         // R9: exactly one tap is active per channel
         p_onehot_r9: assert property (@(posedge clk) disable iff (!sys_rst_n)
            $onehot(tap_sel[p*TAPS +: TAPS]));
      end
   endgenerate

   potbank_timer #(.CYCLES(STORE_CYCLES)) timer_i (
      .clk   (clk),
      .rst_n (sys_rst_n),
      .start (store_ok),
      .busy  (store_busy)
   );

   logic [DATA_W-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      case (op)
         OP_RD_WIPER: rd_next = wiper[cmd_pot];
         OP_RD_SLOT:  rd_next = slots_all[cmd_pot][cmd_reg*DATA_W +: DATA_W];
         OP_RD_BUSY:  rd_next = {{(DATA_W-1){1'b0}}, store_busy};
         default:     rd_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!sys_rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= cmd_valid && is_read(op);
         if (cmd_valid && is_read(op)) rd_data <= rd_next;
      end
   end

   // R7: protected stores leave every data register untouched
   p_wp_block_r7: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (cmd_valid && is_store(op) && !wp_n) |=> $stable(slots_all));
   // R6: a store during a running store is dropped
   p_busy_drop_r6: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (cmd_valid && is_store(op) && store_busy) |=> $stable(slots_all));
   // R8: the status byte carries the busy flag of the command cycle
   p_status_r8: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (cmd_valid && op == OP_RD_BUSY) |=>
         (rd_valid && rd_data == {{(DATA_W-1){1'b0}}, $past(store_busy)}));
endmodule

// File: tb/potbank_top_tb.sv
module potbank_top_tb_top;
   localparam int SC = 6;

   logic        clk = 1'b0;
   logic        por_n = 1'b0, rst_n = 1'b0, wp_n = 1'b1;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_op = '0;
   logic [1:0]  cmd_pot = '0, cmd_reg = '0;
   logic [7:0]  cmd_wdata = '0;
   logic        rd_valid, store_busy;
   logic [7:0]  rd_data;
   logic [1023:0] tap_sel;

   int errors = 0, checks = 0;

   always #2 clk = ~clk;

   potbank_top #(.STORE_CYCLES(SC)) dut_i (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .wp_n(wp_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pot(cmd_pot),
      .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .store_busy(store_busy), .tap_sel(tap_sel)
   );

   typedef struct packed {
      logic [3:0] op;
      logic [1:0] pot;
      logic [1:0] rg;
      logic [7:0] dat;
      logic       chk;
      logic [7:0] exp;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t VEC [NV] = '{
      '{4'd1, 2'd0, 2'd0, 8'h00, 1'b1, 8'h80, 4'd1},   // R1 wiper recalled from init
      '{4'd2, 2'd0, 2'd0, 8'h12, 1'b0, 8'h00, 4'd2},
      '{4'd1, 2'd0, 2'd0, 8'h00, 1'b1, 8'h12, 4'd2},   // R2 direct write
      '{4'd2, 2'd1, 2'd0, 8'hFE, 1'b0, 8'h00, 4'd3},
      '{4'd9, 2'd1, 2'd0, 8'h01, 1'b0, 8'h00, 4'd3},
      '{4'd9, 2'd1, 2'd0, 8'h01, 1'b0, 8'h00, 4'd3},
      '{4'd1, 2'd1, 2'd0, 8'h00, 1'b1, 8'hFF, 4'd3},   // R3 saturate high
      '{4'd2, 2'd2, 2'd0, 8'h01, 1'b0, 8'h00, 4'd3},
      '{4'd9, 2'd2, 2'd0, 8'h00, 1'b0, 8'h00, 4'd3},
      '{4'd9, 2'd2, 2'd0, 8'h00, 1'b0, 8'h00, 4'd3},
      '{4'd1, 2'd2, 2'd0, 8'h00, 1'b1, 8'h00, 4'd3},   // R3 saturate low
      '{4'd4, 2'd3, 2'd2, 8'h5A, 1'b0, 8'h00, 4'd5},
      '{4'd3, 2'd3, 2'd2, 8'h00, 1'b1, 8'h5A, 4'd5},   // R5 data write
      '{4'd5, 2'd3, 2'd2, 8'h00, 1'b0, 8'h00, 4'd4},
      '{4'd1, 2'd3, 2'd0, 8'h00, 1'b1, 8'h5A, 4'd4},   // R4 single load
      '{4'd7, 2'd0, 2'd2, 8'h00, 1'b0, 8'h00, 4'd4},
      '{4'd1, 2'd0, 2'd0, 8'h00, 1'b1, 8'h80, 4'd4},   // R4 global load
      '{4'd1, 2'd3, 2'd0, 8'h00, 1'b1, 8'h5A, 4'd4},
      '{4'd2, 2'd1, 2'd0, 8'h33, 1'b0, 8'h00, 4'd5},
      '{4'd6, 2'd1, 2'd1, 8'h00, 1'b0, 8'h00, 4'd5},
      '{4'd3, 2'd1, 2'd1, 8'h00, 1'b1, 8'h33, 4'd5},   // R5 single save
      '{4'd8, 2'd0, 2'd3, 8'h00, 1'b0, 8'h00, 4'd5},
      '{4'd3, 2'd1, 2'd3, 8'h00, 1'b1, 8'h33, 4'd5},   // R5 global save
      '{4'd3, 2'd3, 2'd3, 8'h00, 1'b1, 8'h5A, 4'd5},
      '{4'd3, 2'd0, 2'd1, 8'h00, 1'b1, 8'h80, 4'd10}   // R10 untouched register
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int tap_of(input int p);
      int idx = -1;
      int n = 0;
      for (int i = 0; i < 256; i++)
         if (tap_sel[p*256 + i]) begin idx = i; n++; end
      return (n == 1) ? idx : -1;
   endfunction

   task automatic issue(input logic [3:0] op, input logic [1:0] pot,
                        input logic [1:0] rg, input logic [7:0] dat);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_pot = pot; cmd_reg = rg; cmd_wdata = dat;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #400000;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
   end

   initial begin
      idle(4);
      por_n = 1'b1; rst_n = 1'b1;
      @(negedge clk);
      // R1 / R9 reset state
      for (int p = 0; p < 4; p++) check("R1 reset tap", tap_of(p), 8'h80);
      check("R6 idle after reset", store_busy, 0);
      check("R8 no read after reset", rd_valid, 0);

      for (int v = 0; v < NV; v++) begin
         issue(VEC[v].op, VEC[v].pot, VEC[v].rg, VEC[v].dat);
         if (VEC[v].chk) begin
            checks++;
            if (!rd_valid || rd_data != VEC[v].exp) begin
               errors++;
               $display("FAIL R%0d vector %0d: actual=%0h valid=%0b expected=%0h",
                        VEC[v].req, v, rd_data, rd_valid, VEC[v].exp);
            end
         end
         if (VEC[v].op == 4'd4 || VEC[v].op == 4'd6 || VEC[v].op == 4'd8) idle(SC + 2);
      end

      // R6 busy window length
      issue(4'd4, 2'd0, 2'd1, 8'h11);
      for (int k = 1; k <= SC; k++) begin
         check("R6 busy high", store_busy, 1);
         @(negedge clk);
      end
      check("R6 busy low after window", store_busy, 0);

      // R6 drop during busy, wiper still moves; R8 status read
      issue(4'd4, 2'd0, 2'd2, 8'h77);
      issue(4'd4, 2'd0, 2'd1, 8'h22);
      issue(4'd2, 2'd0, 2'd0, 8'h44);
      issue(4'd10, 2'd0, 2'd0, 8'h00);
      check("R8 status busy", rd_data, 1);
      idle(SC + 2);
      issue(4'd3, 2'd0, 2'd1, 8'h00);
      check("R6 dropped store", rd_data, 8'h11);
      issue(4'd3, 2'd0, 2'd2, 8'h00);
      check("R6 accepted store", rd_data, 8'h77);
      check("R6 wiper during busy", tap_of(0), 8'h44);
      issue(4'd10, 2'd0, 2'd0, 8'h00);
      check("R8 status idle", rd_data, 0);

      // R7 write protect
      wp_n = 1'b0;
      issue(4'd4, 2'd0, 2'd0, 8'h99);
      check("R7 no busy", store_busy, 0);
      issue(4'd2, 2'd1, 2'd0, 8'hAB);
      issue(4'd8, 2'd0, 2'd0, 8'h00);
      check("R7 no busy global", store_busy, 0);
      issue(4'd3, 2'd0, 2'd0, 8'h00);
      check("R7 blocked write", rd_data, 8'h80);
      issue(4'd3, 2'd1, 2'd0, 8'h00);
      check("R7 blocked global save", rd_data, 8'h80);
      check("R7 wiper moves", tap_of(1), 8'hAB);
      wp_n = 1'b1;

      // R1 soft reset recall, data survives
      issue(4'd4, 2'd2, 2'd0, 8'h3C);
      idle(SC + 2);
      issue(4'd2, 2'd2, 2'd0, 8'h00);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 recall pot2", tap_of(2), 8'h3C);
      check("R1 recall pot1", tap_of(1), 8'h80);
      issue(4'd3, 2'd0, 2'd1, 8'h00);
      check("R1 data survives soft reset", rd_data, 8'h11);

      finish_run();
   end
endmodule